// File: doc/BRIEF.md
# Serial Frame Aligner and Demultiplexer

This block sits behind a clock and data recovery stage. It receives a clean, already sampled serial stream, one bit per clock, and cuts it into parallel frames. At run time a width select picks one of two frame sizes. A wide frame is 24 bits: a 4-bit control field and 20 data bits. A narrow frame is 20 bits: a 4-bit control field and 16 data bits. The control field is sent first, and its most significant bit leads the frame.

Every legal frame has a guaranteed transition inside its control field, called the marker. The block uses the marker to find the frame boundary and then to keep it. While it is hunting, it tests every bit position for the marker. Once it has seen the marker at the same boundary over several frames in a row, it declares lock. After lock it hands each completed frame to the downstream control decoder with a one-cycle strobe. If the marker is missing for several frames in a row, lock is lost and the hunt starts again.

Top module: `frame_aligner`

## Requirements
- R1: While reset is asserted and immediately after it, `locked`, `frame_stb`, `ctrl_out` and `data_out` are all zero.
- R2: With `wide_mode` = 1 a frame is 24 bits long; with `wide_mode` = 0 it is 20 bits long. While locked, `frame_stb` pulses exactly once per frame, in the cycle after the frame's last bit is sampled.
- R3: The first four bits of a frame, the first received bit being bit 3, appear on `ctrl_out[3:0]`. The remaining bits appear on `data_out`, with the earliest bit in the most significant position. In narrow mode `data_out[19:16]` is zero.
- R4: The marker is present when control bits 2 and 1 differ. A frame in which they are equal counts as a missing marker, whatever its other bits are.
- R5: While hunting, the first bit position at which the marker appears becomes the candidate boundary. When the marker is seen at that boundary in 4 consecutive frames, `locked` rises in the cycle after the fourth frame's last bit, together with that frame's strobe. A frame without the marker during this confirmation sends the block back to hunting.
- R6: While locked, three consecutive frames without the marker clear `locked` in the cycle after the third such frame ends. That third frame is still delivered with a strobe.
- R7: While locked, one or two consecutive frames without the marker keep `locked` high. A frame carrying the marker restarts the miss count.
- R8: `ctrl_out` and `data_out` change only together with a `frame_stb` pulse and hold their value between pulses.
- R9: A change of `wide_mode` drops lock at the first clock edge that sees the new value, produces no strobe, and restarts the hunt in the new width.
- R10: `frame_stb` is never high for two consecutive cycles and is never produced while the block is hunting or confirming a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_in | input | 1 | Serial data, one bit per clock |
| wide_mode | input | 1 | 1: 24-bit frames, 0: 20-bit frames |
| ctrl_out | output | 4 | Control field of the last delivered frame |
| data_out | output | 20 | Data field of the last delivered frame, zero-extended in narrow mode |
| frame_stb | output | 1 | One-cycle pulse when a frame is delivered |
| locked | output | 1 | High while a frame boundary is held |

## Verification
The bench builds the block with its default parameters: 16 and 20 data bits, 4 frames to lock and 3 missed frames to unlock. Because these counts are small, the bench can drive acquisition, tolerated misses, loss of lock and reacquisition many times in a few thousand cycles. It covers both widths, and it switches width in both directions while the block is locked. Random frames with random markers and data, mixed with short runs of bad frames, check the field split and the hold behaviour at every bit position.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;
  localparam int CTRL_W  = 4;
  localparam int MARK_HI = 2;
  localparam int MARK_LO = 1;

  typedef enum logic [1:0] {
    LS_SEARCH  = 2'd0,
    LS_CONFIRM = 2'd1,
    LS_LOCKED  = 2'd2
  } lock_state_e;
endpackage

// File: rtl/fa_shift_window.sv
module fa_shift_window
  import frame_align_pkg::*;
#(
  parameter int DW_N = 16,
  parameter int DW_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              wide,
  output logic [CTRL_W-1:0] ctrl_c,
  output logic [DW_W-1:0]   data_c,
  output logic              mark
);
  localparam int FW_N = CTRL_W + DW_N;
  localparam int FW_W = CTRL_W + DW_W;

  logic [FW_W-2:0] sr_q;
  logic [FW_W-1:0] win;

  // newest bit enters at position 0; oldest candidate bit sits at the top
  always_comb begin
    win = {sr_q, bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= win[FW_W-2:0];
  end

  generate
    if (DW_W > DW_N) begin : g_pad
      always_comb begin
        if (wide) begin
          ctrl_c = win[FW_W-1 -: CTRL_W];
          data_c = win[DW_W-1:0];
        end else begin
          ctrl_c = win[FW_N-1 -: CTRL_W];
          data_c = {{(DW_W-DW_N){1'b0}}, win[DW_N-1:0]};
        end
      end
    end else begin : g_same
      always_comb begin
        ctrl_c = win[FW_W-1 -: CTRL_W];
        data_c = win[DW_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    mark = ctrl_c[MARK_HI] ^ ctrl_c[MARK_LO];
  end
endmodule

// File: rtl/fa_lock_ctrl.sv
module fa_lock_ctrl
  import frame_align_pkg::*;
#(
  parameter int FW_N        = 20,
  parameter int FW_W        = 24,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide,
  input  logic mark,
  output logic take,
  output logic locked
);
  localparam int CNT_W = $clog2(FW_W);
  localparam int GW    = $clog2(LOCK_FRAMES + 1);
  localparam int BW    = $clog2(MISS_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST_N    = CNT_W'(FW_N - 1);
  localparam logic [CNT_W-1:0] LAST_W    = CNT_W'(FW_W - 1);
  localparam logic [GW-1:0]    GOOD_DONE = GW'(LOCK_FRAMES - 1);
  localparam logic [BW-1:0]    BAD_DONE  = BW'(MISS_FRAMES - 1);

  lock_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GW-1:0]    good_q, good_d;
  logic [BW-1:0]    bad_q, bad_d;
  logic             mode_q;
  logic             at_end, mode_flip;

  always_comb begin
    at_end    = (cnt_q == (wide ? LAST_W : LAST_N));
    mode_flip = (wide != mode_q);
    st_d      = st_q;
    cnt_d     = at_end ? '0 : cnt_q + 1'b1;
    good_d    = good_q;
    bad_d     = bad_q;
    take      = 1'b0;
    if (mode_flip) begin
      st_d   = LS_SEARCH;
      cnt_d  = '0;
      good_d = '0;
      bad_d  = '0;
    end else begin
      case (st_q)
        LS_SEARCH: begin
          cnt_d = '0;
          if (mark) begin
            st_d   = LS_CONFIRM;
            good_d = GW'(1);
          end
        end
        LS_CONFIRM: begin
          if (at_end) begin
            if (!mark) begin
              st_d   = LS_SEARCH;
              good_d = '0;
            end else if (good_q == GOOD_DONE) begin
              st_d   = LS_LOCKED;
              good_d = '0;
              bad_d  = '0;
              take   = 1'b1;
            end else begin
              good_d = good_q + 1'b1;
            end
          end
        end
        LS_LOCKED: begin
          if (at_end) begin
            take = 1'b1;
            if (mark) begin
              bad_d = '0;
            end else if (bad_q == BAD_DONE) begin
              st_d  = LS_SEARCH;
              bad_d = '0;
            end else begin
              bad_d = bad_q + 1'b1;
            end
          end
        end
        default: begin
          st_d   = LS_SEARCH;
          cnt_d  = '0;
          good_d = '0;
          bad_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_SEARCH;
      cnt_q  <= '0;
      good_q <= '0;
      bad_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      good_q <= good_d;
      bad_q  <= bad_d;
      mode_q <= wide;
    end
  end

  always_comb begin
    locked = (st_q == LS_LOCKED);
  end

  // R5: lock is only ever declared on a frame that carried the marker
  p_lock_on_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(mark));

  // R9: a width change clears lock on the next edge
  p_mode_flip_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wide != $past(wide)) |=> !locked);

  // R6: the miss run never reaches the drop threshold while still locked
  p_miss_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q < BW'(MISS_FRAMES));

  // R2: the bit counter stays inside the frame of the current width
  p_cnt_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wide == mode_q) |-> (cnt_q <= (wide ? LAST_W : LAST_N)));
endmodule

// File: rtl/fa_out_hold.sv
module fa_out_hold #(
  parameter int CW = 4,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] ctrl_in,
  input  logic [DW-1:0] data_in,
  output logic [CW-1:0] ctrl_out,
  output logic [DW-1:0] data_out,
  output logic          stb
);
  logic [CW-1:0] ctrl_d;
  logic [DW-1:0] data_d;

  always_comb begin
    ctrl_d = take ? ctrl_in : ctrl_out;
    data_d = take ? data_in : data_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_out <= '0;
      data_out <= '0;
      stb      <= 1'b0;
    end else begin
      ctrl_out <= ctrl_d;
      data_out <= data_d;
      stb      <= take;
    end
  end

  // R8: fields stay put in every cycle without a strobe
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |-> ($stable(ctrl_out) && $stable(data_out)));
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import frame_align_pkg::*;
#(
  parameter int DATA_W_NARROW = 16,
  parameter int DATA_W_WIDE   = 20,
  parameter int LOCK_FRAMES   = 4,
  parameter int MISS_FRAMES   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_in,
  input  logic                   wide_mode,
  output logic [CTRL_W-1:0]      ctrl_out,
  output logic [DATA_W_WIDE-1:0] data_out,
  output logic                   frame_stb,
  output logic                   locked
);
  localparam int FW_N = CTRL_W + DATA_W_NARROW;
  localparam int FW_W = CTRL_W + DATA_W_WIDE;

  logic [1:0]             rst_pipe;
  logic                   rst_int_n;
  logic [CTRL_W-1:0]      ctrl_c;
  logic [DATA_W_WIDE-1:0] data_c;
  logic                   mark, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  fa_shift_window #(.DW_N(DATA_W_NARROW), .DW_W(DATA_W_WIDE)) u_win (
    .clk(clk), .rst_n(rst_int_n), .bit_in(bit_in), .wide(wide_mode),
    .ctrl_c(ctrl_c), .data_c(data_c), .mark(mark)
  );

  fa_lock_ctrl #(.FW_N(FW_N), .FW_W(FW_W), .LOCK_FRAMES(LOCK_FRAMES),
                 .MISS_FRAMES(MISS_FRAMES)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .wide(wide_mode), .mark(mark),
    .take(take), .locked(locked)
  );

  fa_out_hold #(.CW(CTRL_W), .DW(DATA_W_WIDE)) u_out (
    .clk(clk), .rst_n(rst_int_n), .take(take), .ctrl_in(ctrl_c),
    .data_in(data_c), .ctrl_out(ctrl_out), .data_out(data_out), .stb(frame_stb)
  );

  // R10: strobe lasts one cycle
  p_stb_single_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_stb |=> !frame_stb);

  // R10: strobe only around a held boundary
  p_stb_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_stb |-> (locked || $past(locked)));

  generate
    if (DATA_W_WIDE > DATA_W_NARROW) begin : g_chk_pad
      // R3: narrow frames leave the upper data bits clear
      p_narrow_pad_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
        (frame_stb && !$past(wide_mode)) |->
          (data_out[DATA_W_WIDE-1:DATA_W_NARROW] == '0));
    end
  endgenerate
endmodule

// File: tb/tb_frame_aligner.sv
module tb_frame_aligner;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] SYNC_C = 4'b0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic        wide_mode = 1'b0;
  logic [3:0]  ctrl_out;
  logic [19:0] data_out;
  logic        frame_stb, locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_aligner dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .wide_mode(wide_mode),
    .ctrl_out(ctrl_out), .data_out(data_out), .frame_stb(frame_stb), .locked(locked)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] rand_ctrl();
    logic [3:0] c;
    c = 4'($urandom);
    c[1] = ~c[2];
    return c;
  endfunction

  // shifts one frame out MSB first; called and returns at a falling edge
  task automatic send_frame(input logic [3:0] c, input logic [19:0] d, input bit w,
                            output int mids, output logic endstb, output bit held);
    int n;
    logic [23:0] f;
    logic [3:0]  c0;
    logic [19:0] d0;
    n = w ? 24 : 20;
    f = w ? {c, d} : {4'b0, c, d[15:0]};
    c0 = ctrl_out;
    d0 = data_out;
    mids = 0;
    held = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      bit_in = f[i];
      @(negedge clk);
      if (i != 0) begin
        if (frame_stb) mids++;
        if (ctrl_out !== c0 || data_out !== d0) held = 1'b0;
      end
    end
    endstb = frame_stb;
  endtask

  task automatic good_frame(input string req, input logic [3:0] c,
                            input logic [19:0] d, input bit w);
    int m; logic e; bit h;
    send_frame(c, d, w, m, e, h);
    chk(req, "strobe at frame end", 32'(e), 1);
    chk("R10", "no mid-frame strobe", m, 0);
    chk("R8", "outputs held mid-frame", 32'(h), 1);
    chk(req, "ctrl field", 32'(ctrl_out), 32'(c));
    chk("R3", "data field", 32'(data_out), w ? 32'(d) : 32'(d[15:0]));
    chk(req, "still locked", 32'(locked), 1);
  endtask

  task automatic acquire(input string req, input bit w);
    int m; logic e; bit h;
    for (int k = 1; k <= 4; k++) begin
      send_frame(SYNC_C, 20'h0, w, m, e, h);
      chk("R10", "no strobe while confirming", m, 0);
      if (k < 4) begin
        chk(req, "not yet locked", 32'(locked), 0);
        chk("R10", "no end strobe before lock", 32'(e), 0);
      end else begin
        chk(req, "locked after 4th frame", 32'(locked), 1);
        chk(req, "strobe with lock", 32'(e), 1);
        chk("R3", "sync ctrl delivered", 32'(ctrl_out), 32'(SYNC_C));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int m; logic e; bit h;
    logic [3:0] c; logic [19:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1", "locked in reset", 32'(locked), 0);
    chk("R1", "strobe in reset", 32'(frame_stb), 0);
    chk("R1", "ctrl in reset", 32'(ctrl_out), 0);
    chk("R1", "data in reset", 32'(data_out), 0);
    rst_n = 1'b1;
    send_frame(4'h0, 20'h0, 1'b0, m, e, h);
    chk("R1", "idle after reset", 32'(locked), 0);

    // narrow acquisition and random traffic
    acquire("R5", 1'b0);
    for (int i = 0; i < 20; i++) begin
      c = rand_ctrl(); d = 20'($urandom);
      good_frame("R2", c, d, 1'b0);
    end

    // tolerated misses
    for (int i = 0; i < 2; i++) begin
      send_frame(4'h0, 20'h0, 1'b0, m, e, h);
      chk("R7", "miss keeps lock", 32'(locked), 1);
      chk("R7", "missed frame delivered", 32'(e), 1);
    end
    good_frame("R7", rand_ctrl(), 20'($urandom), 1'b0);
    send_frame(4'h0, 20'h0, 1'b0, m, e, h);
    chk("R7", "count restarted", 32'(locked), 1);
    good_frame("R7", rand_ctrl(), 20'($urandom), 1'b0);

    // loss of lock by zero frames
    for (int i = 1; i <= 3; i++) begin
      send_frame(4'h0, 20'h0, 1'b0, m, e, h);
      chk("R6", "strobe on missed frame", 32'(e), 1);
      chk("R6", "lock after miss", 32'(locked), (i < 3) ? 1 : 0);
    end
    send_frame(4'h0, 20'h0, 1'b0, m, e, h);
    chk("R10", "no strobe while hunting", 32'(e) + 32'(m), 0);

    // relock, then lose lock through frames with equal marker bits
    acquire("R5", 1'b0);
    for (int i = 1; i <= 3; i++) begin
      send_frame(4'b1110, 20'($urandom), 1'b0, m, e, h);
      chk("R4", "equal marker bits count as miss", 32'(locked), (i < 3) ? 1 : 0);
    end
    send_frame(4'h0, 20'h0, 1'b0, m, e, h);
    send_frame(4'h0, 20'h0, 1'b0, m, e, h);
    chk("R5", "bad confirm returns to hunt", 32'(locked), 0);
    acquire("R5", 1'b0);

    // switch to wide while locked
    send_frame(4'h0, 20'h0, 1'b0, m, e, h);
    chk("R7", "one miss before switch", 32'(locked), 1);
    wide_mode = 1'b1;
    send_frame(SYNC_C, 20'h0, 1'b1, m, e, h);
    chk("R9", "width change drops lock", 32'(locked), 0);
    chk("R9", "no strobe after width change", 32'(e) + 32'(m), 0);
    for (int k = 2; k <= 4; k++) begin
      send_frame(SYNC_C, 20'h0, 1'b1, m, e, h);
      chk("R9", "relock in new width", 32'(locked), (k == 4) ? 1 : 0);
    end

    // wide random traffic with short miss runs
    for (int i = 0; i < 150; i++) begin
      if (($urandom % 4) == 0) begin
        for (int j = 0; j <= int'($urandom % 2); j++) begin
          send_frame(4'h0, 20'h0, 1'b1, m, e, h);
          chk("R7", "short miss run keeps lock", 32'(locked), 1);
          chk("R3", "zero frame delivered", 32'(ctrl_out) + 32'(data_out), 0);
        end
      end
      c = rand_ctrl(); d = 20'($urandom);
      good_frame("R2", c, d, 1'b1);
    end

    // back to narrow
    send_frame(4'h0, 20'h0, 1'b1, m, e, h);
    wide_mode = 1'b0;
    acquire("R9", 1'b0);
    for (int i = 0; i < 30; i++) begin
      c = rand_ctrl(); d = 20'($urandom);
      good_frame("R3", c, d, 1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule